// File: doc/BRIEF.md
# Transmit Low-Power-Idle Controller

This block decides when an Ethernet MAC transmitter may put the link into low-power idle and when it must wake it again. It watches a transmit-idle flag, a pending-frame request and the PHY link state. When automatic entry is allowed and the link has been good for a programmable number of milliseconds, it raises a TX low-power-idle indication toward the PHY. A frame request, or software turning the feature off, ends low-power idle. A programmable wake wait, counted in microseconds, then passes before the transmitter is reported ready again.

The block also watches the receive-side low-power-idle indication from the PHY. Entry and exit transitions on both paths are recorded as sticky event flags. These flags drive an interrupt, and software clears them all at once by reading the control/status word. A free-running 1 µs tick paces both timers. A prescaler inside the block divides that tick into milliseconds.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset the control word reads 0, the timer word (offset 0x34) reads 0x03E8_0000 (link-stable time 1000 ms, wake wait 0), `tx_lpi_out` and `lpi_irq` are low, and `tx_ready` is high.
- R2: The timer word keeps the wake wait in bits 15:0 and the link-stable time in bits 26:16. Its other bits read as zero.
- R3: In the control word (offset 0x30), bit 16 enables low-power idle and bit 19 enables automatic entry. With both set, `tx_lpi_out` rises only while `tx_idle` is high, `tx_pending` is low and the link has been good for the link-stable time, measured in units of US_PER_MS ticks. The TX-entry event bit 0 is set on the same clock edge.
- R4: The link counts as good when `phy_link_good` is high and, if control bit 18 is set, control bit 17 is also set. Any loss of link restarts the link-stable count from zero.
- R5: While in low-power idle, a high `tx_pending` or a cleared bit 16 drops `tx_lpi_out` on the next edge and sets the TX-exit event bit 1.
- R6: After `tx_lpi_out` drops, `tx_ready` stays low for the wake-wait count of `us_tick` pulses and then rises. With a wake wait of 0 it rises on the same edge that `tx_lpi_out` falls. `tx_ready` is low throughout low-power idle.
- R7: Control bit 9 shows the registered RX low-power-idle state and bit 8 shows the TX state. A rise of `rx_lpi_in` sets event bit 2 and a fall sets event bit 3.
- R8: A read of the control word returns the event bits as they stood, then clears bits 3:0, so `lpi_irq` falls on the next edge if no new event arrives.
- R9: `lpi_irq` is high, and bit 10 of the interrupt summary word at offset 0x38 reads 1, whenever any event bit is pending. Reading the summary word clears nothing.
- R10: No low-power-idle entry happens while `tx_pending` is high or while the wake wait is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| tx_idle | input | 1 | Transmit path has nothing in flight |
| tx_pending | input | 1 | A frame is waiting to be sent |
| phy_link_good | input | 1 | PHY reports link up |
| rx_lpi_in | input | 1 | Receive path is in low-power idle |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| tx_lpi_out | output | 1 | Assert low-power idle toward the PHY |
| tx_ready | output | 1 | Transmitter may send data |
| lpi_irq | output | 1 | An event flag is pending |

## Verification
The hardest situation to reach is the exact edge where a freshly restored link completes its stable window, because the millisecond prescaler and the link-stable counter must both restart together. The stimulus shortens the millisecond to a few ticks through the parameter, drops the link (or the software link bit with link-status use enabled), restores it at a known cycle, and checks that the output is still low just before the window closes and high just after. A wake with a non-zero wait and a wake with a zero wait are both driven, so the two ready paths are each compared against their expected cycle.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

    localparam logic [7:0] OFS_CTRL  = 8'h30;
    localparam logic [7:0] OFS_TIMER = 8'h34;
    localparam logic [7:0] OFS_ISR   = 8'h38;

    localparam int LS_W         = 11;
    localparam int TW_W         = 16;
    localparam int LS_RESET     = 1000;
    localparam int TW_RESET     = 0;
    localparam int ISR_LPI_BIT  = 10;

    typedef enum logic [1:0] {
        TX_ACTIVE = 2'd0,
        TX_SLEEP  = 2'd1,
        TX_WAKE   = 2'd2
    } tx_state_e;

    // Ordered to match word bits 19..16
    typedef struct packed {
        logic auto_en;
        logic link_use;
        logic link_sw;
        logic lpi_en;
    } lpi_ctrl_t;

    // Ordered to match word bits 3..0
    typedef struct packed {
        logic rx_leave;
        logic rx_enter;
        logic tx_leave;
        logic tx_enter;
    } lpi_evt_t;

    function automatic logic [31:0] ctrl_word(lpi_ctrl_t c, logic rx_live,
                                              logic tx_live, lpi_evt_t e);
        logic [31:0] w;
        w          = '0;
        w[19:16]   = c;
        w[9]       = rx_live;
        w[8]       = tx_live;
        w[3:0]     = e;
        return w;
    endfunction

    function automatic logic [31:0] timer_word(logic [LS_W-1:0] ls,
                                               logic [TW_W-1:0] tw);
        logic [31:0] w;
        w                 = '0;
        w[16 +: LS_W]     = ls;
        w[TW_W-1:0]       = tw;
        return w;
    endfunction

endpackage

// File: rtl/eee_lpi_regs.sv
module eee_lpi_regs
    import eee_lpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  lpi_evt_t          new_evt,
    input  logic              rx_live,
    input  logic              tx_live,
    output lpi_ctrl_t         ctrl,
    output logic [LS_W-1:0]   ls_val,
    output logic [TW_W-1:0]   tw_val,
    output logic              irq
);
    lpi_evt_t evt_q;
    logic     rd_ctrl;
    logic [31:0] isr_word;

    assign rd_ctrl = rd_en && (addr == OFS_CTRL);

    always_comb begin
        isr_word = '0;
        isr_word[ISR_LPI_BIT] = |evt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            ls_val <= LS_W'(LS_RESET);
            tw_val <= TW_W'(TW_RESET);
        end else if (wr_en) begin
            if (addr == OFS_CTRL) begin
                ctrl <= lpi_ctrl_t'(wdata[19:16]);
            end else if (addr == OFS_TIMER) begin
                ls_val <= wdata[16 +: LS_W];
                tw_val <= wdata[TW_W-1:0];
            end
        end
    end

    // New events win over the read-clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else begin
            evt_q <= (rd_ctrl ? lpi_evt_t'('0) : evt_q) | new_evt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                OFS_CTRL:  rdata <= ctrl_word(ctrl, rx_live, tx_live, evt_q);
                OFS_TIMER: rdata <= timer_word(ls_val, tw_val);
                OFS_ISR:   rdata <= isr_word;
                default:   rdata <= '0;
            endcase
        end
    end

    assign irq = |evt_q;

endmodule

// File: rtl/eee_lpi_linkwin.sv
module eee_lpi_linkwin
    import eee_lpi_pkg::*;
#(
    parameter int US_PER_MS = 1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            us_tick,
    input  logic            link_ok,
    input  logic [LS_W-1:0] ls_val,
    output logic            link_stable
);
    localparam int PRE_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(US_PER_MS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [LS_W-1:0]  ms_q;
    logic             ms_tick;

    assign ms_tick = link_ok && us_tick && (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || !link_ok) begin
            pre_q <= '0;
        end else if (us_tick) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !link_ok) begin
            ms_q <= '0;
        end else if (ms_tick && (ms_q < ls_val)) begin
            ms_q <= ms_q + 1'b1;
        end
    end

    assign link_stable = link_ok && (ms_q >= ls_val);

endmodule

// File: rtl/eee_lpi_txfsm.sv
module eee_lpi_txfsm
    import eee_lpi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            us_tick,
    input  lpi_ctrl_t       ctrl,
    input  logic            tx_idle,
    input  logic            tx_pending,
    input  logic            link_stable,
    input  logic [TW_W-1:0] tw_val,
    output logic            tx_lpi,
    output logic            tx_ready,
    output logic            evt_enter,
    output logic            evt_leave
);
    tx_state_e       st_q, st_d;
    logic [TW_W-1:0] wait_q;
    logic            go_sleep, go_wake, wait_done;

    assign go_sleep  = ctrl.lpi_en && ctrl.auto_en && tx_idle &&
                       !tx_pending && link_stable;
    assign go_wake   = tx_pending || !ctrl.lpi_en;
    assign wait_done = us_tick && (wait_q == tw_val - 1'b1);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_ACTIVE: if (go_sleep) st_d = TX_SLEEP;
            TX_SLEEP:  if (go_wake)  st_d = (tw_val == '0) ? TX_ACTIVE : TX_WAKE;
            TX_WAKE:   if (wait_done) st_d = TX_ACTIVE;
            default:   st_d = TX_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= TX_ACTIVE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || st_q != TX_WAKE) begin
            wait_q <= '0;
        end else if (us_tick) begin
            wait_q <= wait_q + 1'b1;
        end
    end

    assign evt_enter = (st_q == TX_ACTIVE) && (st_d == TX_SLEEP);
    assign evt_leave = (st_q == TX_SLEEP)  && (st_d != TX_SLEEP);
    assign tx_lpi    = (st_q == TX_SLEEP);
    assign tx_ready  = (st_q == TX_ACTIVE);

endmodule

// File: rtl/eee_lpi_rxmon.sv
module eee_lpi_rxmon (
    input  logic clk,
    input  logic rst,
    input  logic rx_lpi_in,
    output logic rx_live,
    output logic evt_enter,
    output logic evt_leave
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_live <= 1'b0;
        end else begin
            rx_live <= rx_lpi_in;
        end
    end

    assign evt_enter = rx_lpi_in && !rx_live;
    assign evt_leave = !rx_lpi_in && rx_live;

endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
    import eee_lpi_pkg::*;
#(
    parameter int US_PER_MS = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_idle,
    input  logic        tx_pending,
    input  logic        phy_link_good,
    input  logic        rx_lpi_in,
    input  logic        us_tick,
    output logic        tx_lpi_out,
    output logic        tx_ready,
    output logic        lpi_irq
);
    lpi_ctrl_t       ctrl;
    lpi_evt_t        evt;
    logic [LS_W-1:0] ls_val;
    logic [TW_W-1:0] tw_val;
    logic            link_ok, link_stable, rx_live;
    logic            tx_in, tx_out, rx_in, rx_out;

    assign link_ok = phy_link_good && (!ctrl.link_use || ctrl.link_sw);

    always_comb begin
        evt          = '0;
        evt.tx_enter = tx_in;
        evt.tx_leave = tx_out;
        evt.rx_enter = rx_in;
        evt.rx_leave = rx_out;
    end

    eee_lpi_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .new_evt(evt), .rx_live(rx_live), .tx_live(tx_lpi_out),
        .ctrl(ctrl), .ls_val(ls_val), .tw_val(tw_val), .irq(lpi_irq)
    );

    eee_lpi_linkwin #(.US_PER_MS(US_PER_MS)) u_linkwin (
        .clk(clk), .rst(rst), .us_tick(us_tick), .link_ok(link_ok),
        .ls_val(ls_val), .link_stable(link_stable)
    );

    eee_lpi_txfsm u_txfsm (
        .clk(clk), .rst(rst), .us_tick(us_tick), .ctrl(ctrl),
        .tx_idle(tx_idle), .tx_pending(tx_pending),
        .link_stable(link_stable), .tw_val(tw_val),
        .tx_lpi(tx_lpi_out), .tx_ready(tx_ready),
        .evt_enter(tx_in), .evt_leave(tx_out)
    );

    eee_lpi_rxmon u_rxmon (
        .clk(clk), .rst(rst), .rx_lpi_in(rx_lpi_in),
        .rx_live(rx_live), .evt_enter(rx_in), .evt_leave(rx_out)
    );

endmodule

// File: rtl/eee_lpi_ctrl_chk.sv
module eee_lpi_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic tx_idle,
    input logic tx_pending,
    input logic rx_lpi_in,
    input logic tx_lpi_out,
    input logic tx_ready,
    input logic lpi_irq
);
    // R3: entry only from an idle path with nothing waiting
    p_entry_gate_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_lpi_out) |-> $past(tx_idle && !tx_pending));

    // R3: entry event raises the interrupt on the same edge
    p_entry_evt_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_lpi_out) |-> lpi_irq);

    // R5: exit event raises the interrupt on the same edge
    p_exit_evt_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_lpi_out) |-> lpi_irq);

    // R6: never ready while in low-power idle
    p_sleep_not_ready_r6: assert property (@(posedge clk) disable iff (rst)
        tx_lpi_out |-> !tx_ready);

    // R10: a waiting frame blocks entry
    p_no_entry_pending_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_pending && !tx_lpi_out) |=> !tx_lpi_out);

    // R7: receive-side entry is flagged one edge later
    p_rx_evt_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_lpi_in) |=> lpi_irq);

endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .tx_idle(tx_idle), .tx_pending(tx_pending),
    .rx_lpi_in(rx_lpi_in), .tx_lpi_out(tx_lpi_out),
    .tx_ready(tx_ready), .lpi_irq(lpi_irq)
);

// File: tb/eee_lpi_ctrl_tb_top.sv
`timescale 1ns/1ps
module eee_lpi_ctrl_tb_top;

    localparam int MS_DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_idle = 1'b1, tx_pending = 1'b0, phy_link_good = 1'b1;
    logic        rx_lpi_in = 1'b0, us_tick = 1'b1;
    logic        tx_lpi_out, tx_ready, lpi_irq;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [31:0] value;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    logic      rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    eee_lpi_ctrl #(.US_PER_MS(MS_DIV)) dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_idle(tx_idle), .tx_pending(tx_pending),
        .phy_link_good(phy_link_good), .rx_lpi_in(rx_lpi_in),
        .us_tick(us_tick), .tx_lpi_out(tx_lpi_out), .tx_ready(tx_ready),
        .lpi_irq(lpi_irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data against the scoreboard queue
    always @(posedge clk) rd_seen <= reg_rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(reg_rdata, 32'hDEAD_BEEF, "scoreboard underflow");
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(reg_rdata, it.value, it.tag);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_expect(input logic [7:0] a, input logic [31:0] d,
                              input string tag);
        exp_item_t it;
        it.value = d; it.tag = tag;
        @(negedge clk);
        exp_q.push_back(it);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic port_chk(input logic lpi, input logic rdy, input logic irq,
                            input string tag);
        check({29'd0, tx_lpi_out, tx_ready, lpi_irq}, {29'd0, lpi, rdy, irq}, tag);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);

        // Reset state
        port_chk(1'b0, 1'b1, 1'b0, "R1 ports after reset");
        reg_expect(8'h34, 32'h03E8_0000, "R1 timer reset");
        reg_expect(8'h30, 32'h0000_0000, "R1 ctrl reset");

        // Timer field layout
        reg_write(8'h34, 32'hFFFF_FFFF);
        reg_expect(8'h34, 32'h07FF_FFFF, "R2 timer mask");
        reg_write(8'h34, (32'd3 << 16) | 32'd5);
        reg_expect(8'h34, 32'h0003_0005, "R2 timer fields");

        // Link down blocks entry; restore and time the window
        phy_link_good = 1'b0;
        reg_write(8'h30, 32'h0009_0000);
        cycles(5);
        port_chk(1'b0, 1'b1, 1'b0, "R4 link down holds off entry");
        phy_link_good = 1'b1;
        cycles(11);
        port_chk(1'b0, 1'b1, 1'b0, "R3 window not yet elapsed");
        cycles(3);
        port_chk(1'b1, 1'b0, 1'b1, "R3 entry after window");
        reg_expect(8'h38, 32'h0000_0400, "R9 summary bit set");
        reg_expect(8'h30, 32'h0009_0101, "R3 R7 entry event and live tx");
        port_chk(1'b1, 1'b0, 1'b0, "R8 irq cleared by read");

        // Exit by a pending frame, wake wait of 5
        tx_pending = 1'b1;
        cycles(1);
        port_chk(1'b0, 1'b0, 1'b1, "R5 exit on pending");
        cycles(4);
        port_chk(1'b0, 1'b0, 1'b1, "R6 ready held during wake");
        cycles(1);
        port_chk(1'b0, 1'b1, 1'b1, "R6 ready after wake");
        cycles(4);
        port_chk(1'b0, 1'b1, 1'b1, "R10 no entry while pending");
        reg_expect(8'h30, 32'h0009_0002, "R5 exit event");

        // Re-entry, then exit by clearing enable with zero wake wait
        tx_pending = 1'b0;
        cycles(1);
        port_chk(1'b1, 1'b0, 1'b1, "R3 re-entry with stable link");
        reg_expect(8'h30, 32'h0009_0101, "R8 read returns then clears");
        reg_write(8'h34, 32'h0003_0000);
        reg_write(8'h30, 32'h0008_0000);
        cycles(1);
        port_chk(1'b0, 1'b1, 1'b1, "R5 R6 enable cleared, zero wait");
        reg_expect(8'h30, 32'h0008_0002, "R5 exit event on disable");

        // Software link status gating
        reg_write(8'h30, 32'h000D_0000);
        cycles(20);
        port_chk(1'b0, 1'b1, 1'b0, "R4 link bit low blocks entry");
        reg_write(8'h30, 32'h000F_0000);
        cycles(11);
        port_chk(1'b0, 1'b1, 1'b0, "R4 window restarts on link bit");
        cycles(3);
        port_chk(1'b1, 1'b0, 1'b1, "R4 entry after link bit window");
        reg_expect(8'h30, 32'h000F_0101, "R4 entry event");

        // Receive-side events
        rx_lpi_in = 1'b1;
        cycles(1);
        port_chk(1'b1, 1'b0, 1'b1, "R7 rx entry raises irq");
        reg_expect(8'h30, 32'h000F_0304, "R7 rx entry and live bits");
        rx_lpi_in = 1'b0;
        cycles(1);
        reg_expect(8'h38, 32'h0000_0400, "R9 summary on rx exit");
        reg_expect(8'h30, 32'h000F_0108, "R7 rx exit event");
        reg_expect(8'h38, 32'h0000_0000, "R9 summary clear");
        port_chk(1'b1, 1'b0, 1'b0, "R9 irq low when none pending");

        cycles(2);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule